// File: doc/BRIEF.md
# Two-Cycle Configurable Byte Multiplier

This block is the multiply unit of a small RISC core. The core presents two operand bytes, a 3-bit mode code and a one-cycle start strobe. Two clock edges later the unit delivers a 16-bit product, split into a high byte and a low byte so the core can write them to a register pair. In the same cycle it raises a one-cycle done pulse and presents updated zero and carry flags. The core keeps every other status flag itself. The unit does not touch them.

The mode code selects how the operands are interpreted and whether the product is scaled. Bits [1:0] choose the signedness: both operands unsigned, both signed, or first operand signed with the second unsigned. Bit [2] selects the fractional form, which moves the product up by one place for fixed-point operands. While an operation is in flight, the unit accepts no new strobe. A new operation can start in the same cycle that done is shown, so one result is produced every two cycles.

Top module: `mul8_unit`

## Requirements
- R1: After reset, `done_o`, `flag_z_o`, `flag_c_o`, `prod_hi_o` and `prod_lo_o` are all zero.
- R2: A start strobe sampled while the unit is idle is accepted. `done_o` is high in the cycle after the second rising edge that follows the acceptance, and it stays high for exactly one cycle.
- R3: Mode bits [1:0] = 00 or 11 multiply both operands as unsigned values.
- R4: Mode bits [1:0] = 01 multiply both operands as two's complement signed values.
- R5: Mode bits [1:0] = 10 sign-extend the first operand (`opa_i`) and zero-extend the second operand (`opb_i`) before multiplying.
- R6: Mode bit [2] = 1 shifts the 16-bit product left by one place, with a zero entering bit 0. Mode bit [2] = 0 leaves the product unshifted. `prod_hi_o` carries result bits [15:8] and `prod_lo_o` carries bits [7:0].
- R7: `flag_c_o` takes bit 15 of the product before any fractional shift.
- R8: `flag_z_o` is 1 exactly when the final 16-bit result, after any shift, is zero.
- R9: A start strobe sampled in the cycle after an acceptance is ignored. It produces no extra done pulse and no change to the pending result.
- R10: Between done pulses, `prod_hi_o`, `prod_lo_o`, `flag_z_o` and `flag_c_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| mode_i | input | 3 | Bit 2: fractional shift; bits 1:0: signedness |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| done_o | output | 1 | One-cycle pulse marking a new result |
| flag_z_o | output | 1 | Zero flag of the latest result |
| flag_c_o | output | 1 | Carry flag of the latest result |

## Verification
A wrong operand extension shows up as a miscompare in the product bytes at the very next done pulse. It appears only for operands with the top bit set, so the vectors lean on 0x80 and 0xFF corners in every mode. A stuck or duplicated busy state shows up within two cycles, as a done pulse that arrives too early, too late or twice, or as a result that does not match the first strobe. Any corruption of the held result is seen in the idle cycles that follow a done pulse.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  // signedness selection, mode bits [1:0]
  typedef enum logic [1:0] {
    SG_UU  = 2'b00,
    SG_SS  = 2'b01,
    SG_SU  = 2'b10,
    SG_UU3 = 2'b11
  } sgn_e;

  localparam int MODE_W   = 3;
  localparam int FRAC_BIT = 2;
endpackage

// File: rtl/mul8_opnd_ext.sv
module mul8_opnd_ext #(
  parameter int W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  mul8_pkg::sgn_e  sgn_i,
  output logic [W:0]      xa_o,
  output logic [W:0]      xb_o
);
  import mul8_pkg::*;

  // widen one operand by a single bit, copying the sign or inserting zero
  function automatic logic [W:0] widen(input logic [W-1:0] v, input logic signed_v);
    return {signed_v & v[W-1], v};
  endfunction

  logic a_sgn, b_sgn;

  always_comb begin
    a_sgn = (sgn_i == SG_SS) || (sgn_i == SG_SU);
    b_sgn = (sgn_i == SG_SS);
    xa_o  = widen(a_i, a_sgn);
    xb_o  = widen(b_i, b_sgn);
  end
endmodule

// File: rtl/mul8_array.sv
module mul8_array #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [W:0]    xa_i,
  input  logic [W:0]    xb_i,
  output logic [PW-1:0] raw_o
);
  localparam int FW = 2 * (W + 1);

  // signed product of two widened operands, low PW bits kept
  function automatic logic [PW-1:0] smul(input logic [W:0] x, input logic [W:0] y);
    logic signed [FW-1:0] p;
    p = FW'($signed(x)) * FW'($signed(y));
    return p[PW-1:0];
  endfunction

  assign raw_o = smul(xa_i, xb_i);
endmodule

// File: rtl/mul8_post.sv
module mul8_post #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic [PW-1:0] raw_i,
  input  logic          frac_i,
  output logic [PW-1:0] res_o,
  output logic          z_o,
  output logic          c_o
);
  function automatic logic [PW-1:0] scale(input logic [PW-1:0] v, input logic f);
    return f ? {v[PW-2:0], 1'b0} : v;
  endfunction

  always_comb begin
    res_o = scale(raw_i, frac_i);
    c_o   = raw_i[PW-1];
    z_o   = (res_o == '0);
  end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [mul8_pkg::MODE_W-1:0]  mode_i,
  input  logic [W-1:0]                 opa_i,
  input  logic [W-1:0]                 opb_i,
  output logic [W-1:0]                 prod_hi_o,
  output logic [W-1:0]                 prod_lo_o,
  output logic                         done_o,
  output logic                         flag_z_o,
  output logic                         flag_c_o
);
  import mul8_pkg::*;

  // stage 1: operand latch
  logic             busy_w;
  logic             accept_w;
  logic [W-1:0]     a_q, b_q;
  sgn_e             sgn_q;
  logic             frac_q;

  assign accept_w = start_i & ~busy_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_w <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      sgn_q  <= SG_UU;
      frac_q <= 1'b0;
    end else begin
      busy_w <= accept_w;
      if (accept_w) begin
        a_q    <= opa_i;
        b_q    <= opb_i;
        sgn_q  <= sgn_e'(mode_i[1:0]);
        frac_q <= mode_i[FRAC_BIT];
      end
    end
  end

  // stage 2: multiply and post-process
  logic [W:0]    xa_w, xb_w;
  logic [PW-1:0] raw_w, res_w;
  logic          z_w, c_w;

  mul8_opnd_ext #(.W(W)) u_ext (
    .a_i(a_q), .b_i(b_q), .sgn_i(sgn_q), .xa_o(xa_w), .xb_o(xb_w)
  );

  mul8_array #(.W(W)) u_arr (
    .xa_i(xa_w), .xb_i(xb_w), .raw_o(raw_w)
  );

  mul8_post #(.W(W)) u_post (
    .raw_i(raw_w), .frac_i(frac_q), .res_o(res_w), .z_o(z_w), .c_o(c_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      prod_hi_o <= '0;
      prod_lo_o <= '0;
      flag_z_o  <= 1'b0;
      flag_c_o  <= 1'b0;
    end else begin
      done_o <= busy_w;
      if (busy_w) begin
        prod_hi_o <= res_w[PW-1:W];
        prod_lo_o <= res_w[W-1:0];
        flag_z_o  <= z_w;
        flag_c_o  <= c_w;
      end
    end
  end
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         accept_w,
  input logic         busy_w,
  input logic         frac_q,
  input logic         done_o,
  input logic [W-1:0] prod_hi_o,
  input logic [W-1:0] prod_lo_o,
  input logic         flag_z_o,
  input logic         flag_c_o
);
  // R2: done follows an accepted start after two edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> ##1 done_o);

  // R2: done is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a strobe during the busy cycle is not taken
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start_i) |=> !busy_w);

  // R6: fractional results carry a zero in bit 0
  a_r6_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && frac_q) |-> (prod_lo_o[0] == 1'b0));

  // R8: zero flag agrees with the presented result
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (flag_z_o == ({prod_hi_o, prod_lo_o} == '0)));

  // R10: outputs hold while no result is presented
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(prod_hi_o) && $stable(prod_lo_o) &&
                 $stable(flag_z_o) && $stable(flag_c_o)));
endmodule

bind mul8_unit mul8_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_w(accept_w),
  .busy_w(busy_w), .frac_q(frac_q), .done_o(done_o),
  .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
  .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
);

// File: tb/mul8_unit_tb.sv
module mul8_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [7:0] opa_i = '0;
  logic [7:0] opb_i = '0;
  logic [7:0] prod_hi_o, prod_lo_o;
  logic       done_o, flag_z_o, flag_c_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [15:0] res;
    logic        z;
    logic        c;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [15:0] last_res;
  logic        last_z, last_c;

  mul8_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .opa_i(opa_i), .opb_i(opb_i), .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .done_o(done_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
  );

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference: interpret operands as integers and scale
  function automatic exp_t model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    exp_t e;
    int ia, ib, p;
    logic [15:0] raw;
    ia = int'(a);
    ib = int'(b);
    if ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a >= 8'h80) ia = ia - 256;
    if (m[1:0] == 2'b01 && b >= 8'h80) ib = ib - 256;
    p   = ia * ib;
    raw = p[15:0];
    e.c   = raw[15];
    e.res = m[2] ? {raw[14:0], 1'b0} : raw;
    e.z   = (e.res == 16'h0);
    return e;
  endfunction

  // driver: one accepted operation; optional second strobe in busy cycle
  task automatic issue(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                       input string tag, input bit poke_busy);
    exp_t e;
    @(negedge clk);
    e = model(m, a, b);
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
    start_i = 1'b1; mode_i = m; opa_i = a; opb_i = b;
    @(negedge clk);
    if (poke_busy) begin
      start_i = 1'b1; mode_i = ~m; opa_i = ~a; opb_i = b ^ 8'h5A;  // R9 stimulus
    end else
      start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "done with no pending operation", 32'(done_o), 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R2", {e.tag, " done timing"}, 32'(cyc), 32'(e.due));
        check({prod_hi_o, prod_lo_o} == e.res, e.tag, "product",
              32'({prod_hi_o, prod_lo_o}), 32'(e.res));
        check(flag_c_o == e.c, "R7", {e.tag, " carry"}, 32'(flag_c_o), 32'(e.c));
        check(flag_z_o == e.z, "R8", {e.tag, " zero"}, 32'(flag_z_o), 32'(e.z));
      end
      last_res = {prod_hi_o, prod_lo_o};
      last_z   = flag_z_o;
      last_c   = flag_c_o;
    end
  end

  // watchdog
  initial begin
    wait (cyc > 100000);
    check(1'b0, "WDOG", "run did not finish", 32'(cyc), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({done_o, flag_z_o, flag_c_o, prod_hi_o, prod_lo_o} == 19'h0, "R1",
          "reset outputs", 32'({done_o, flag_z_o, flag_c_o, prod_hi_o, prod_lo_o}), 32'h0);

    // R3 unsigned corners (codes 00 and 11)
    issue(3'b000, 8'hFF, 8'hFF, "R3", 1'b0);
    issue(3'b011, 8'h80, 8'h02, "R3", 1'b0);
    issue(3'b000, 8'h00, 8'h9C, "R3", 1'b0);
    // R4 signed corners
    issue(3'b001, 8'h80, 8'h80, "R4", 1'b0);
    issue(3'b001, 8'hFF, 8'h01, "R4", 1'b0);
    issue(3'b001, 8'h7F, 8'h80, "R4", 1'b0);
    // R5 signed by unsigned
    issue(3'b010, 8'h80, 8'hFF, "R5", 1'b0);
    issue(3'b010, 8'hFF, 8'hFF, "R5", 1'b0);
    issue(3'b010, 8'h7F, 8'h80, "R5", 1'b0);
    // R6 fractional variants
    issue(3'b100, 8'hFF, 8'hFF, "R6", 1'b0);
    issue(3'b101, 8'h80, 8'h80, "R6", 1'b0);
    issue(3'b110, 8'h80, 8'hFF, "R6", 1'b0);
    issue(3'b101, 8'h00, 8'h80, "R6", 1'b0);
    // R9: second strobe during busy cycle
    issue(3'b001, 8'h12, 8'h34, "R9", 1'b1);
    issue(3'b110, 8'hC3, 8'h3C, "R9", 1'b1);

    // R10: outputs hold while idle
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check({prod_hi_o, prod_lo_o} == last_res && flag_z_o == last_z && flag_c_o == last_c,
            "R10", "hold while idle", 32'({flag_z_o, flag_c_o, prod_hi_o, prod_lo_o}),
            32'({last_z, last_c, last_res}));
      check(done_o == 1'b0, "R2", "no done while idle", 32'(done_o), 32'h0);
      @(negedge clk);
    end

    // random sweep across all modes
    for (int n = 0; n < 400; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      issue(m, 8'($urandom), 8'($urandom), m[2] ? "R6" : "R3/R4/R5", n[0]);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "results outstanding at end", 32'(sb.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule